// File: doc/BRIEF.md
# Peripheral Request Line to DMA Channel Mapper

This block sits between the peripheral DMA request lines of a chip and the per-channel status logic of its DMA engine. A table with one entry per request line names the DMA channel that the line drives and says whether that mapping is live. Software programs the table through a small 32-bit register port. The entries live in two separate address windows.

The block samples every request line once. It then looks for level changes on the mapped lines and keeps one current request level per channel. For every change it sends single-cycle event pulses to the channel status block. A line that turns on while its channel was idle raises a request-after-stop event. A line that turns off while its channel was requesting raises an end-of-receive event. Any update that does not raise request-after-stop clears it. A separate pulse tells the transfer scheduler that some channel has just seen an active request.

Top module: `req_chan_mapper`

## Requirements
- R1: After reset every channel level is 0, no event pulse, scheduler pulse or error is asserted, and every map entry reads 0.
- R2: Map entries for request lines 0 to 63 sit at byte addresses 0x100 + 4·n. Each entry reads back as bits 4:0 = target channel, bit 7 = mapping valid, and every other bit 0, whatever was written there.
- R3: Map entries for request lines 64 to 74 sit at byte addresses 0x1100 + 4·(n − 64) and behave as in R2.
- R4: A write that sets bit 7 with a channel field at or above NUM_CH (16 by default) is rejected. reg_err pulses high in the cycle after the write, and the entry keeps its old value.
- R5: A request line whose entry has bit 7 clear is ignored: its changes move no channel level and produce no pulse.
- R6: When a mapped line turns on while its channel level is 0, ch_ras_set for that channel pulses and the channel level becomes 1. Both are visible in the second cycle after the input change (one input register, one event register).
- R7: When a mapped line turns off while its channel level is 1, ch_eor_set pulses for that channel and the channel level becomes 0, with the same latency as R6.
- R8: Every update on a channel that does not raise ch_ras_set pulses ch_ras_clr for that channel instead. ch_ras_set and ch_ras_clr are never high together.
- R9: sched_kick pulses in the same cycle as any channel update whose new level is active, and never while all channel levels are 0.
- R10: If several mapped lines that target the same channel change in the same cycle, only the lowest-numbered of them updates that channel.
- R11: Addresses 0xE0, 0xE4 and 0xE8 (request status) read as 0, and writes to them have no effect. Reads return data in the cycle after reg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | NUM_REQ (75) | Peripheral request lines, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| reg_err | output | 1 | Pulse: illegal channel number in a map write |
| ch_level | output | NUM_CH (16) | Current request level per channel |
| ch_ras_set | output | NUM_CH (16) | Pulse: set request-after-stop status |
| ch_ras_clr | output | NUM_CH (16) | Pulse: clear request-after-stop status |
| ch_eor_set | output | NUM_CH (16) | Pulse: set end-of-receive status |
| sched_kick | output | 1 | Pulse: an active request update occurred |

## Verification
The bench sends two lines to one channel. A rising edge that arrives while the channel is already requesting must give a clear pulse and no set pulse. A design that keys on the line's own edge instead of the channel level would give the wrong event. One directed case has a lower-numbered line rising while a higher-numbered line on the same channel falls in the same cycle. A design with the wrong priority would drop the level and emit end-of-receive. Further cases write an out-of-range channel and then read the entry back, to catch a design that stores it anyway. A write to the status addresses must not land in the table, and the last entry of the upper window tests the window offset arithmetic.

// File: rtl/req_chan_mapper_pkg.sv
// Shared constants for the request-to-channel mapper: register layout of a
// map entry and the address windows that hold the table.
package req_chan_mapper_pkg;
    localparam int CH_FIELD_W  = 5;          // width of the channel field, bits 4:0
    localparam int VALID_BIT   = 7;          // mapping-valid flag position
    localparam int LOW_WIN_N   = 64;         // entries in the low window
    localparam logic [15:0] LOW_WIN_BASE  = 16'h0100;
    localparam logic [15:0] HIGH_WIN_BASE = 16'h1100;
    localparam logic [15:0] STAT_ADDR0    = 16'h00E0;
    localparam logic [15:0] STAT_ADDR1    = 16'h00E4;
    localparam logic [15:0] STAT_ADDR2    = 16'h00E8;
endpackage

// File: rtl/req_chan_map_table.sv
// Map table with its register port. Holds one entry (valid + channel) per
// request line, decodes the two address windows and rejects writes that name
// a channel that does not exist. Assumes single-cycle read/write strobes.
module req_chan_map_table
    import req_chan_mapper_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  reg_wr,
    input  logic                                  reg_rd,
    input  logic [15:0]                           reg_addr,
    input  logic [31:0]                           reg_wdata,
    output logic [31:0]                           reg_rdata,
    output logic                                  reg_err,
    output logic [NUM_REQ-1:0]                    map_vld,
    output logic [NUM_REQ-1:0][CH_FIELD_W-1:0]    map_ch
);
    localparam int HIGH_WIN_N = NUM_REQ - LOW_WIN_N;
    localparam int IDX_W      = $clog2(NUM_REQ);
    localparam logic [15:0] LOW_WIN_LAST  = LOW_WIN_BASE  + 16'(4 * (LOW_WIN_N - 1));
    localparam logic [15:0] HIGH_WIN_LAST = HIGH_WIN_BASE + 16'(4 * (HIGH_WIN_N - 1));

    logic             hit;
    logic             stat_hit;
    logic [IDX_W-1:0] idx;
    logic [15:0]      offs;
    logic             illegal;
    logic             unused_wbits;

    assign unused_wbits = ^{reg_wdata[31:8], reg_wdata[6:5]};

    // Address decode: find which table entry, if any, the access targets.
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        offs = '0;
        if (reg_addr[1:0] == 2'b00) begin
            if (reg_addr >= LOW_WIN_BASE && reg_addr <= LOW_WIN_LAST) begin
                hit  = 1'b1;
                offs = (reg_addr - LOW_WIN_BASE) >> 2;
                idx  = IDX_W'(offs);
            end else if (reg_addr >= HIGH_WIN_BASE && reg_addr <= HIGH_WIN_LAST) begin
                hit  = 1'b1;
                offs = ((reg_addr - HIGH_WIN_BASE) >> 2) + 16'(LOW_WIN_N);
                idx  = IDX_W'(offs);
            end
        end
    end

    assign stat_hit = (reg_addr == STAT_ADDR0) || (reg_addr == STAT_ADDR1) ||
                      (reg_addr == STAT_ADDR2);

    // A valid mapping to a channel number that does not exist is illegal.
    assign illegal = reg_wdata[VALID_BIT] &&
                     ({1'b0, reg_wdata[CH_FIELD_W-1:0]} >= (CH_FIELD_W+1)'(NUM_CH));

    // Table storage: legal writes update the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_vld <= '0;
            map_ch  <= '0;
        end else if (reg_wr && hit && !illegal) begin
            map_vld[idx] <= reg_wdata[VALID_BIT];
            map_ch[idx]  <= reg_wdata[CH_FIELD_W-1:0];
        end
    end

    // Error pulse for a rejected table write.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_err <= 1'b0;
        else        reg_err <= reg_wr && hit && illegal;
    end

    // Registered read data; status registers and holes read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            if (hit)
                reg_rdata <= {24'b0, map_vld[idx], 2'b00, map_ch[idx]};
            else
                reg_rdata <= '0;
        end
    end

    // R4
    illegal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit && illegal) |=> ($stable(map_vld) && $stable(map_ch) && reg_err));

    // R4
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> $past(reg_wr));

    // R11
    stat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && stat_hit) |=> (reg_rdata == 32'd0));
endmodule

// File: rtl/req_edge_detect.sv
// Registers every request line once and reports which lines changed
// between the last two samples. Assumes inputs may be asynchronous to
// nothing beyond one sample (already in the clock domain).
module req_edge_detect #(
    parameter int NUM_REQ = 75
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_in,
    output logic [NUM_REQ-1:0] req_lvl,
    output logic [NUM_REQ-1:0] req_chg
);
    logic [NUM_REQ-1:0] req_prev;

    // Input sample and one-cycle history for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_lvl  <= '0;
            req_prev <= '0;
        end else begin
            req_lvl  <= req_in;
            req_prev <= req_lvl;
        end
    end

    assign req_chg = req_lvl ^ req_prev;
endmodule

// File: rtl/req_chan_route.sv
// Per-channel routing: for each channel picks the lowest-numbered changed
// request line mapped to it, updates the channel level and emits the
// status event pulses. Assumes map entries with channel >= NUM_CH never exist.
module req_chan_route
    import req_chan_mapper_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_REQ-1:0]                 req_lvl,
    input  logic [NUM_REQ-1:0]                 req_chg,
    input  logic [NUM_REQ-1:0]                 map_vld,
    input  logic [NUM_REQ-1:0][CH_FIELD_W-1:0] map_ch,
    output logic [NUM_CH-1:0]                  ch_level,
    output logic [NUM_CH-1:0]                  ch_ras_set,
    output logic [NUM_CH-1:0]                  ch_ras_clr,
    output logic [NUM_CH-1:0]                  ch_eor_set,
    output logic                               sched_kick
);
    logic [NUM_CH-1:0] upd;
    logic [NUM_CH-1:0] new_on;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Priority pick: scan downward so the lowest-numbered line wins.
        always_comb begin
            upd[c]    = 1'b0;
            new_on[c] = 1'b0;
            for (int r = NUM_REQ - 1; r >= 0; r--) begin
                if (req_chg[r] && map_vld[r] && (map_ch[r] == CH_FIELD_W'(c))) begin
                    upd[c]    = 1'b1;
                    new_on[c] = req_lvl[r];
                end
            end
        end
    end

    // Channel level and event pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_level   <= '0;
            ch_ras_set <= '0;
            ch_ras_clr <= '0;
            ch_eor_set <= '0;
            sched_kick <= 1'b0;
        end else begin
            ch_level   <= (upd & new_on) | (~upd & ch_level);
            ch_ras_set <= upd & new_on & ~ch_level;
            ch_ras_clr <= upd & ~(new_on & ~ch_level);
            ch_eor_set <= upd & ~new_on & ch_level;
            sched_kick <= |(upd & new_on);
        end
    end

    // R6
    ras_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |ch_ras_set |-> ((ch_ras_set & ~ch_level) == '0));

    // R7
    eor_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |ch_eor_set |-> ((ch_eor_set & ch_level) == '0));

    // R8
    ras_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_ras_set & ch_ras_clr) == '0);

    // R9
    kick_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sched_kick |-> (ch_level != '0));
endmodule

// File: rtl/req_chan_mapper.sv
// Top of the request-to-channel mapper: sample/edge stage, map table with
// register port, and per-channel router. Assumes NUM_REQ > 64 and NUM_CH <= 32.
module req_chan_mapper
    import req_chan_mapper_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_in,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [15:0]        reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               reg_err,
    output logic [NUM_CH-1:0]  ch_level,
    output logic [NUM_CH-1:0]  ch_ras_set,
    output logic [NUM_CH-1:0]  ch_ras_clr,
    output logic [NUM_CH-1:0]  ch_eor_set,
    output logic               sched_kick
);
    logic [NUM_REQ-1:0]                 req_lvl;
    logic [NUM_REQ-1:0]                 req_chg;
    logic [NUM_REQ-1:0]                 map_vld;
    logic [NUM_REQ-1:0][CH_FIELD_W-1:0] map_ch;

    req_edge_detect #(.NUM_REQ(NUM_REQ)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_in  (req_in),
        .req_lvl (req_lvl),
        .req_chg (req_chg)
    );

    req_chan_map_table #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_err   (reg_err),
        .map_vld   (map_vld),
        .map_ch    (map_ch)
    );

    req_chan_route #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_lvl    (req_lvl),
        .req_chg    (req_chg),
        .map_vld    (map_vld),
        .map_ch     (map_ch),
        .ch_level   (ch_level),
        .ch_ras_set (ch_ras_set),
        .ch_ras_clr (ch_ras_clr),
        .ch_eor_set (ch_eor_set),
        .sched_kick (sched_kick)
    );
endmodule

// File: tb/req_chan_mapper_bench.sv
// Directed bench for req_chan_mapper: one task per scenario.
module req_chan_mapper_bench;
    localparam int NREQ = 75;
    localparam int NCH  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NREQ-1:0] req_in = '0;
    logic            reg_wr = 1'b0;
    logic            reg_rd = 1'b0;
    logic [15:0]     reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            reg_err;
    logic [NCH-1:0]  ch_level, ch_ras_set, ch_ras_clr, ch_eor_set;
    logic            sched_kick;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    req_chan_mapper #(.NUM_REQ(NREQ), .NUM_CH(NCH)) u_req_chan_mapper (
        .clk(clk), .rst_n(rst_n), .req_in(req_in),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
        .ch_level(ch_level), .ch_ras_set(ch_ras_set), .ch_ras_clr(ch_ras_clr),
        .ch_eor_set(ch_eor_set), .sched_kick(sched_kick)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] entry_addr(input int n);
        if (n < 64) return 16'h0100 + 16'(4 * n);
        return 16'h1100 + 16'(4 * (n - 64));
    endfunction

    task automatic reg_write(input logic [15:0] a, input logic [31:0] d, output logic err);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        err = reg_err;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    // Change request lines, then wait the two register stages and return.
    task automatic set_req(input int n, input logic v);
        @(negedge clk);
        req_in[n] = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk(ch_level == '0, "R1 level", 32'(ch_level), 0);
        chk((ch_ras_set | ch_ras_clr | ch_eor_set) == '0 && !sched_kick && !reg_err,
            "R1 pulses", 32'(ch_ras_set | ch_ras_clr | ch_eor_set), 0);
        reg_read(entry_addr(0), d);  chk(d == 0, "R1 entry0", d, 0);
        reg_read(entry_addr(74), d); chk(d == 0, "R1 entry74", d, 0);
    endtask

    task automatic t_map_low();
        logic e; logic [31:0] d;
        reg_write(entry_addr(6), 32'hFFFF_FF45, e);
        reg_read(entry_addr(6), d);  chk(d == 32'h05, "R2 masked readback", d, 32'h05);
        reg_write(entry_addr(3), 32'h82, e);
        reg_read(entry_addr(3), d);  chk(d == 32'h82, "R2 readback req3", d, 32'h82);
        reg_write(entry_addr(63), 32'h8F, e);
        reg_read(entry_addr(63), d); chk(d == 32'h8F, "R2 readback req63", d, 32'h8F);
    endtask

    task automatic t_map_high();
        logic e; logic [31:0] d;
        reg_write(entry_addr(70), 32'h87, e);
        reg_read(entry_addr(70), d); chk(d == 32'h87, "R3 readback req70", d, 32'h87);
        reg_write(entry_addr(74), 32'h8C, e);
        reg_read(entry_addr(74), d); chk(d == 32'h8C, "R3 readback req74", d, 32'h8C);
    endtask

    task automatic t_illegal();
        logic e; logic [31:0] d;
        reg_write(entry_addr(5), 32'h94, e);
        chk(e == 1'b1, "R4 err pulse", 32'(e), 1);
        reg_read(entry_addr(5), d); chk(d == 0, "R4 entry kept", d, 0);
        reg_write(entry_addr(5), 32'h8F, e);
        chk(e == 1'b0, "R4 legal no err", 32'(e), 0);
        reg_write(entry_addr(5), 32'h00, e);
    endtask

    task automatic t_unmapped();
        set_req(10, 1'b1);
        chk(ch_level == '0 && (ch_ras_set | ch_ras_clr) == '0 && !sched_kick,
            "R5 unmapped ignored", 32'(ch_level | ch_ras_set | ch_ras_clr), 0);
        set_req(10, 1'b0);
        chk(ch_eor_set == '0 && ch_level == '0, "R5 unmapped fall", 32'(ch_eor_set), 0);
    endtask

    task automatic t_rise_fall();
        logic e;
        set_req(3, 1'b1);   // req3 -> ch2
        chk(ch_ras_set == 16'h0004 && ch_level == 16'h0004,
            "R6 ras set ch2", {ch_ras_set, ch_level}, {16'h0004, 16'h0004});
        chk(sched_kick == 1'b1, "R9 kick on rise", 32'(sched_kick), 1);
        @(negedge clk);
        chk(ch_ras_set == '0 && !sched_kick, "R6 pulse one cycle", 32'(ch_ras_set), 0);
        reg_write(entry_addr(4), 32'h82, e);
        set_req(4, 1'b1);   // second line, channel already requesting
        chk(ch_ras_clr == 16'h0004 && ch_ras_set == '0 && ch_level == 16'h0004,
            "R8 ras clr on busy rise", {ch_ras_clr, ch_ras_set}, {16'h0004, 16'h0});
        set_req(3, 1'b0);
        chk(ch_eor_set == 16'h0004 && ch_level == '0 && ch_ras_clr == 16'h0004,
            "R7 eor on fall", {ch_eor_set, ch_level}, {16'h0004, 16'h0});
        chk(!sched_kick, "R9 no kick on fall", 32'(sched_kick), 0);
        set_req(4, 1'b0);
        chk(ch_eor_set == '0 && ch_ras_clr == 16'h0004,
            "R8 clr on idle fall", {ch_eor_set, ch_ras_clr}, {16'h0, 16'h0004});
    endtask

    task automatic t_priority();
        logic e;
        reg_write(entry_addr(20), 32'h89, e);
        reg_write(entry_addr(21), 32'h89, e);
        set_req(21, 1'b1);
        chk(ch_level == 16'h0200, "R10 setup level", 32'(ch_level), 32'h200);
        @(negedge clk);
        req_in[20] = 1'b1; req_in[21] = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(ch_level == 16'h0200 && ch_eor_set == '0 && ch_ras_clr == 16'h0200,
            "R10 lowest wins", {ch_level, ch_eor_set}, {16'h0200, 16'h0});
    endtask

    task automatic t_high_req();
        set_req(70, 1'b1);  // req70 -> ch7
        chk(ch_ras_set == 16'h0080 && ch_level[7], "R6 high window ras",
            32'(ch_ras_set), 32'h80);
    endtask

    task automatic t_status();
        logic e; logic [31:0] d;
        reg_write(16'h00E0, 32'hFFFF_FFFF, e);
        reg_read(16'h00E0, d); chk(d == 0, "R11 stat0 zero", d, 0);
        reg_read(16'h00E4, d); chk(d == 0, "R11 stat1 zero", d, 0);
        reg_read(16'h00E8, d); chk(d == 0, "R11 stat2 zero", d, 0);
        reg_read(entry_addr(0), d); chk(d == 0, "R11 write ignored", d, 0);
    endtask

    initial begin
        #800000;
        total++; bad++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map_low();
        t_map_high();
        t_illegal();
        t_unmapped();
        t_rise_fall();
        t_priority();
        t_high_req();
        t_status();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule